// File: doc/BRIEF.md
# TDM Timeslot Interchange Switch

This block moves bytes between time-division multiplexed streams. Every clock is one channel time. In that clock the switch accepts one byte from each input stream, for the channel that the internal channel counter names. In the same clock it produces one byte for each output stream. The byte for each output channel is chosen by a 16-bit connection word held for that output stream and channel. The word either selects any input stream and channel as the source or carries a fixed message byte.

Received bytes are kept in a data memory of three frame banks. The bank for a frame is the frame count modulo 3. A switched channel may use constant delay, which keeps frame integrity. It may instead use variable delay, which gives the lowest latency. The delay type is chosen separately for each output channel. A global enable gates variable delay for the whole block.

Connection words are written into a shadow copy. The whole copy is made active at the next frame boundary, so an output channel never changes source in the middle of a frame.

Top module: `tsi_switch`

## Requirements
- R1: While `rst_n` is low, `out_data`, `cur_ch` and `out_ch` are all zero and every connection word is zero. Input bytes are accepted from the second clock after `rst_n` rises, starting at channel 0 of frame 0. Data memory locations that have not been written since reset read as zero.
- R2: `cur_ch` counts 0 to NCHAN-1, advancing by one every clock, and then wraps to 0 to start the next frame. The byte for output channel n is placed on `out_data` one clock after the slot where `cur_ch` equals n, and in that clock `out_ch` equals n. Stream k uses bits 8k+7..8k of both `in_data` and `out_data`.
- R3: The connection word has these fields:
  - bit 0 is the message flag;
  - bits 8..1 are the source channel;
  - bits 13..9 are the source stream;
  - bit 14 selects the delay type, 1 for variable and 0 for constant.

  Only the low log2(NCHAN) bits of the source channel field and the low log2(NSTRM) bits of the source stream field are used. The upper bits have no effect.
- R4: In constant delay, a byte accepted on stream s, channel m of frame F leaves on output channel n of frame F+2. The delay is therefore 2 frames + (n-m).
- R5: The constant-delay extremes hold. The source pair (channel NCHAN-1 to channel 0) has a delay of 1 frame + 1 channel. The source pair (channel 0 to channel NCHAN-1) has a delay of 3 frames - 1 channel.
- R6: In variable delay with n-m > 7, the byte leaves in the same frame in which it arrived.
- R7: In variable delay with n-m = 7, the byte leaves in the same frame only if the output stream number is greater than or equal to the source stream number. Otherwise it leaves in the following frame.
- R8: In variable delay with n-m < 7 and not covered by R7, the byte leaves in the following frame, a delay of 1 frame + (n-m).
- R9: A word with bit 0 set outputs bits 10..3 as the channel's byte, whatever its other bits hold.
- R10: A switched word with bit 14 set while `var_en` is low outputs 0xFF. Constant-delay channels are not affected by `var_en`.
- R11: A connection word written in any slot of frame F, including the last slot, is used from frame F+1 onward. Frame F still uses the previous word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Channel-time clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| var_en | input | 1 | Global enable for variable delay |
| in_data | input | NSTRM*8 | Input byte of every stream for channel `cur_ch` |
| cm_we | input | 1 | Connection word write strobe |
| cm_strm | input | log2(NSTRM) | Output stream of the word being written |
| cm_chan | input | log2(NCHAN) | Output channel of the word being written |
| cm_wdata | input | 16 | Connection word |
| cur_ch | output | log2(NCHAN) | Channel accepted in this clock |
| out_ch | output | log2(NCHAN) | Channel carried by `out_data` |
| out_data | output | NSTRM*8 | Output byte of every stream |

## Verification
The bench programs one word for each delay corner:
- the two constant-delay extremes;
- variable pairs with offsets of 10 and 6, with a zero offset, and with a negative offset;
- both sides of the offset-7 stream tie-break;
- messages whose other bits are set.

A wrong bank pointer shifts bytes by a whole frame. Reversing the stream tie-break swaps the frame used for the two offset-7 pairs. Decoding the high field bits selects a different source, and a missed gate lets stale data through where 0xFF is expected.

Mid-frame writes and a write in the last slot are placed so that an immediate update, or one deferred by an extra frame, shows up on the watched channel.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  typedef logic [7:0]  byte_t;
  typedef logic [15:0] cmw_t;

  localparam int MODE_BIT    = 0;
  localparam int SRC_CH_LSB  = 1;
  localparam int SRC_ST_LSB  = 9;
  localparam int DLY_SEL_BIT = 14;
  localparam int MSG_LSB     = 3;

  localparam int    NBANK     = 3;
  localparam int    VAR_LEAD  = 7;
  localparam byte_t FILL_BYTE = 8'hFF;

  typedef enum logic [1:0] {
    OM_SWITCH = 2'd0,
    OM_MSG    = 2'd1,
    OM_FILL   = 2'd2
  } omode_e;
endpackage

// File: rtl/tsi_timebase.sv
module tsi_timebase #(
  parameter int NCHAN = 32,
  parameter int CW    = $clog2(NCHAN)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] ch,
  output logic [1:0]    bank,
  output logic          last
);
  logic [CW-1:0] ch_q, ch_d;
  logic [1:0]    bank_q, bank_d;

  always_comb begin
    last   = (ch_q == CW'(NCHAN - 1));
    ch_d   = last ? '0 : ch_q + CW'(1);
    bank_d = bank_q;
    if (last) begin
      bank_d = (bank_q == 2'd2) ? 2'd0 : bank_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_q   <= '0;
      bank_q <= '0;
    end else begin
      ch_q   <= ch_d;
      bank_q <= bank_d;
    end
  end

  assign ch   = ch_q;
  assign bank = bank_q;

  AST_CH_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (ch_q == '0)); // R2
  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !last |=> $stable(bank_q)); // R2
  AST_BANK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bank_q != 2'd3); // R4
endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem
  import tsi_pkg::*;
#(
  parameter int NSTRM = 4,
  parameter int NCHAN = 32,
  parameter int SW    = $clog2(NSTRM),
  parameter int CW    = $clog2(NCHAN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [SW-1:0]      wr_strm,
  input  logic [CW-1:0]      wr_ch,
  input  cmw_t               wr_word,
  input  logic               boundary,
  input  logic [CW-1:0]      rd_ch,
  output cmw_t [NSTRM-1:0]   rd_word
);
  localparam int NWORD = NSTRM * NCHAN;

  cmw_t [NWORD-1:0] shadow_q, shadow_d;
  cmw_t [NWORD-1:0] active_q, active_d;

  always_comb begin
    shadow_d = shadow_q;
    if (wr_en) begin
      shadow_d[int'(wr_strm) * NCHAN + int'(wr_ch)] = wr_word;
    end
    active_d = active_q;
    if (boundary) begin
      active_d = shadow_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      shadow_q <= shadow_d;
      active_q <= active_d;
    end
  end

  for (genvar s = 0; s < NSTRM; s++) begin : g_rd
    assign rd_word[s] = active_q[s * NCHAN + int'(rd_ch)];
  end

  AST_CM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(active_q)); // R11
endmodule

// File: rtl/tsi_data_mem.sv
module tsi_data_mem
  import tsi_pkg::*;
#(
  parameter int NSTRM = 4,
  parameter int NCHAN = 32,
  parameter int SW    = $clog2(NSTRM),
  parameter int CW    = $clog2(NCHAN)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [1:0]                wr_bank,
  input  logic [CW-1:0]             wr_ch,
  input  byte_t [NSTRM-1:0]         wr_byte,
  input  logic [NSTRM-1:0][1:0]     rd_bank,
  input  logic [NSTRM-1:0][SW-1:0]  rd_strm,
  input  logic [NSTRM-1:0][CW-1:0]  rd_ch,
  output byte_t [NSTRM-1:0]         rd_byte
);
  localparam int DEPTH = NBANK * NSTRM * NCHAN;

  byte_t [DEPTH-1:0] mem_q, mem_d;

  always_comb begin
    mem_d = mem_q;
    for (int s = 0; s < NSTRM; s++) begin
      mem_d[(int'(wr_bank) * NSTRM + s) * NCHAN + int'(wr_ch)] = wr_byte[s];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else begin
      mem_q <= mem_d;
    end
  end

  for (genvar s = 0; s < NSTRM; s++) begin : g_rd
    assign rd_byte[s] =
      mem_q[(int'(rd_bank[s]) * NSTRM + int'(rd_strm[s])) * NCHAN + int'(rd_ch[s])];

    AST_RD_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      rd_bank[s] != 2'd3); // R4
  end
endmodule

// File: rtl/tsi_out_sel.sv
module tsi_out_sel
  import tsi_pkg::*;
#(
  parameter int NSTRM = 4,
  parameter int NCHAN = 32,
  parameter int SW    = $clog2(NSTRM),
  parameter int CW    = $clog2(NCHAN),
  parameter int OIDX  = 0
) (
  input  cmw_t          word,
  input  logic [CW-1:0] out_ch,
  input  logic [1:0]    bank,
  input  logic          var_en,
  output logic [1:0]    rd_bank,
  output logic [SW-1:0] rd_strm,
  output logic [CW-1:0] rd_ch,
  output omode_e        mode,
  output byte_t         msg
);
  logic [CW-1:0] src_ch;
  logic [SW-1:0] src_st;
  logic [1:0]    bank_prev, bank_old;
  logic          lead_ok;
  int            gap;
  logic          unused_word;

  assign unused_word = ^word;

  always_comb begin
    src_ch    = word[SRC_CH_LSB +: CW];
    src_st    = word[SRC_ST_LSB +: SW];
    gap       = int'(out_ch) - int'(src_ch);
    lead_ok   = (gap > VAR_LEAD) || ((gap == VAR_LEAD) && (OIDX >= int'(src_st)));
    bank_prev = (bank == 2'd0) ? 2'd2 : bank - 2'd1;
    bank_old  = (bank == 2'd2) ? 2'd0 : bank + 2'd1;

    rd_strm = src_st;
    rd_ch   = src_ch;
    if (!word[DLY_SEL_BIT]) begin
      rd_bank = bank_old;
    end else if (lead_ok) begin
      rd_bank = bank;
    end else begin
      rd_bank = bank_prev;
    end

    msg = word[MSG_LSB +: 8];
    if (word[MODE_BIT]) begin
      mode = OM_MSG;
    end else if (word[DLY_SEL_BIT] && !var_en) begin
      mode = OM_FILL;
    end else begin
      mode = OM_SWITCH;
    end
  end
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
  import tsi_pkg::*;
#(
  parameter  int NSTRM = 4,
  parameter  int NCHAN = 32,
  localparam int SW    = $clog2(NSTRM),
  localparam int CW    = $clog2(NCHAN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               var_en,
  input  logic [NSTRM*8-1:0] in_data,
  input  logic               cm_we,
  input  logic [SW-1:0]      cm_strm,
  input  logic [CW-1:0]      cm_chan,
  input  logic [15:0]        cm_wdata,
  output logic [CW-1:0]      cur_ch,
  output logic [CW-1:0]      out_ch,
  output logic [NSTRM*8-1:0] out_data
);
  logic [1:0] rs_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= '0;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_n_int = rs_q[1];

  logic [CW-1:0] tb_ch;
  logic [1:0]    tb_bank;
  logic          tb_last;

  tsi_timebase #(.NCHAN(NCHAN), .CW(CW)) u_time (
    .clk   (clk),
    .rst_n (rst_n_int),
    .ch    (tb_ch),
    .bank  (tb_bank),
    .last  (tb_last)
  );

  cmw_t [NSTRM-1:0] cm_word;

  tsi_conn_mem #(.NSTRM(NSTRM), .NCHAN(NCHAN), .SW(SW), .CW(CW)) u_cm (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .wr_en    (cm_we),
    .wr_strm  (cm_strm),
    .wr_ch    (cm_chan),
    .wr_word  (cm_wdata),
    .boundary (tb_last),
    .rd_ch    (tb_ch),
    .rd_word  (cm_word)
  );

  logic [NSTRM-1:0][1:0]    sel_bank;
  logic [NSTRM-1:0][SW-1:0] sel_strm;
  logic [NSTRM-1:0][CW-1:0] sel_ch;
  omode_e                   sel_mode [NSTRM];
  byte_t [NSTRM-1:0]        sel_msg;
  byte_t [NSTRM-1:0]        mem_byte;
  byte_t [NSTRM-1:0]        in_byte;

  assign in_byte = in_data;

  for (genvar g = 0; g < NSTRM; g++) begin : g_sel
    tsi_out_sel #(
      .NSTRM(NSTRM), .NCHAN(NCHAN), .SW(SW), .CW(CW), .OIDX(g)
    ) u_sel (
      .word    (cm_word[g]),
      .out_ch  (tb_ch),
      .bank    (tb_bank),
      .var_en  (var_en),
      .rd_bank (sel_bank[g]),
      .rd_strm (sel_strm[g]),
      .rd_ch   (sel_ch[g]),
      .mode    (sel_mode[g]),
      .msg     (sel_msg[g])
    );
  end

  tsi_data_mem #(.NSTRM(NSTRM), .NCHAN(NCHAN), .SW(SW), .CW(CW)) u_dm (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .wr_bank (tb_bank),
    .wr_ch   (tb_ch),
    .wr_byte (in_byte),
    .rd_bank (sel_bank),
    .rd_strm (sel_strm),
    .rd_ch   (sel_ch),
    .rd_byte (mem_byte)
  );

  byte_t [NSTRM-1:0] out_d, out_q;
  logic  [CW-1:0]    och_q;

  always_comb begin
    for (int s = 0; s < NSTRM; s++) begin
      unique case (sel_mode[s])
        OM_MSG:  out_d[s] = sel_msg[s];
        OM_FILL: out_d[s] = FILL_BYTE;
        default: out_d[s] = mem_byte[s];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      out_q <= '0;
      och_q <= '0;
    end else begin
      out_q <= out_d;
      och_q <= tb_ch;
    end
  end

  assign out_data = out_q;
  assign out_ch   = och_q;
  assign cur_ch   = tb_ch;

  for (genvar g = 0; g < NSTRM; g++) begin : g_chk
    AST_MSG_BYTE: assert property (@(posedge clk) disable iff (!rst_n_int)
      cm_word[g][MODE_BIT] |=> (out_q[g] == $past(cm_word[g][MSG_LSB +: 8]))); // R9
    AST_VAR_FILL: assert property (@(posedge clk) disable iff (!rst_n_int)
      (!cm_word[g][MODE_BIT] && cm_word[g][DLY_SEL_BIT] && !var_en)
        |=> (out_q[g] == FILL_BYTE)); // R10
  end
endmodule

// File: tb/sim_tsi_switch.sv
module sim_tsi_switch;
  localparam int NS = 4;
  localparam int NC = 32;

  logic          clk;
  logic          rst_n;
  logic          var_en;
  logic [NS*8-1:0] in_data;
  logic          cm_we;
  logic [1:0]    cm_strm;
  logic [4:0]    cm_chan;
  logic [15:0]   cm_wdata;
  logic [4:0]    cur_ch;
  logic [4:0]    out_ch;
  logic [NS*8-1:0] out_data;

  tsi_switch #(.NSTRM(NS), .NCHAN(NC)) u0 (
    .clk(clk), .rst_n(rst_n), .var_en(var_en), .in_data(in_data),
    .cm_we(cm_we), .cm_strm(cm_strm), .cm_chan(cm_chan), .cm_wdata(cm_wdata),
    .cur_ch(cur_ch), .out_ch(out_ch), .out_data(out_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {out stream, out channel, connection word}
  localparam logic [22:0] VEC [12] = '{
    {2'd0, 5'd0,  16'h063E},  // R5 const, stream3 ch31 -> ch0
    {2'd0, 5'd31, 16'h0200},  // R5 const, stream1 ch0 -> ch31
    {2'd1, 5'd5,  16'h0428},  // R4 const, stream2 ch20
    {2'd1, 5'd20, 16'h4014},  // R6 var, gap 10
    {2'd2, 5'd15, 16'h4210},  // R7 var, gap 7, out 2 >= src 1
    {2'd1, 5'd16, 16'h4612},  // R7 var, gap 7, out 1 <  src 3
    {2'd2, 5'd9,  16'h4406},  // R8 var, gap 6
    {2'd3, 5'd4,  16'h4008},  // R8 var, gap 0
    {2'd3, 5'd2,  16'h423C},  // R8 var, negative gap
    {2'd2, 5'd0,  16'h8529},  // R9 message A5, bit 15 set
    {2'd3, 5'd12, 16'h0A50},  // R3 stream field 5, channel field 40
    {2'd0, 5'd10, 16'h41E1}   // R9 message 3C, bit 14 set
  };

  int nchk;
  int nfail;
  int t;
  bit done;
  logic [15:0] sh [NS][NC];
  logic [15:0] ac [NS][NC];
  bit vh [8];

  function automatic logic [7:0] src_byte(int f, int s, int m);
    if (f < 0) return 8'h00;
    return 8'((f * 53 + s * 97 + m * 5 + 1) & 255);
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: t=%0d actual %h expected %h", req, t, act, exp);
    end
  endtask

  task automatic check_out();
    int tau, g, n, m, s, d;
    logic [15:0] w;
    logic [7:0] e;
    string lab;
    bit same;
    tau = t - 1;
    g = tau / NC;
    n = tau % NC;
    chk("R2", 16'(out_ch), 16'(n));
    for (int o = 0; o < NS; o++) begin
      w = ac[o][n];
      m = int'(w[5:1]);
      s = int'(w[10:9]);
      if (w[0]) begin
        e = w[10:3];
        lab = "R9";
      end else if (w[14] && !vh[tau % 8]) begin
        e = 8'hFF;
        lab = "R10";
      end else if (w[14]) begin
        d = n - m;
        same = (d > 7) || (d == 7 && o >= s);
        e = same ? src_byte(g, s, m) : src_byte(g - 1, s, m);
        lab = (d == 7) ? "R7" : (same ? "R6" : "R8");
      end else begin
        e = src_byte(g - 2, s, m);
        lab = ((m == NC - 1 && n == 0) || (m == 0 && n == NC - 1)) ? "R5" : "R4";
      end
      if (!w[0] && (w[13:11] != 0 || w[8:6] != 0)) lab = "R3";
      if (o == 1 && n == 20 && (g == 8 || g == 9)) lab = "R11";
      if (o == 2 && n == 0 && (g == 9 || g == 10)) lab = "R11";
      chk(lab, 16'(out_data[o*8 +: 8]), 16'(e));
    end
  endtask

  task automatic step(input bit wr, input int wo, input int wn,
                      input logic [15:0] ww, input bit ven);
    @(negedge clk);
    chk("R2", 16'(cur_ch), 16'(t % NC));
    if (t >= 1) check_out();
    if (t % NC == 0 && t > 0) begin
      for (int o = 0; o < NS; o++)
        for (int c = 0; c < NC; c++) ac[o][c] = sh[o][c];
    end
    var_en = ven;
    vh[t % 8] = ven;
    for (int s = 0; s < NS; s++) in_data[s*8 +: 8] = src_byte(t / NC, s, t % NC);
    cm_we = wr;
    if (wr) begin
      cm_strm  = 2'(wo);
      cm_chan  = 5'(wn);
      cm_wdata = ww;
      sh[wo][wn] = ww;
    end
    t++;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    nchk = 0; nfail = 0; t = 0; done = 0;
    rst_n = 1'b0; var_en = 1'b0; in_data = '0;
    cm_we = 1'b0; cm_strm = '0; cm_chan = '0; cm_wdata = '0;
    for (int o = 0; o < NS; o++)
      for (int c = 0; c < NC; c++) begin sh[o][c] = '0; ac[o][c] = '0; end
    for (int i = 0; i < 8; i++) vh[i] = 1'b0;

    // R1: reset state
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R1", 16'(out_data[15:0]), 16'h0);
      chk("R1", 16'(out_data[31:16]), 16'h0);
      chk("R1", 16'(cur_ch), 16'h0);
      chk("R1", 16'(out_ch), 16'h0);
    end
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);

    // vector table: program words in frame 0, used from frame 1
    for (int i = 0; i < 12; i++)
      step(1'b1, int'(VEC[i][22:21]), int'(VEC[i][20:16]), VEC[i][15:0], 1'b1);
    while (t < 5 * NC) step(1'b0, 0, 0, 16'h0, 1'b1);
    // R10: variable enable cleared for two frames
    while (t < 7 * NC) step(1'b0, 0, 0, 16'h0, 1'b0);
    while (t < 8 * NC + 10) step(1'b0, 0, 0, 16'h0, 1'b1);
    // R11: mid-frame write, channel 20 of stream 1 changes only in frame 9
    step(1'b1, 1, 20, 16'h02D1, 1'b1);
    while (t < 9 * NC + 31) step(1'b0, 0, 0, 16'h0, 1'b1);
    // R11: write in the last slot of frame 9, used in frame 10
    step(1'b1, 2, 0, 16'h03B9, 1'b1);
    while (t < 13 * NC + 1) step(1'b0, 0, 0, 16'h0, 1'b1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule